// File: doc/BRIEF.md
# Delayed Spike Scheduler

This block turns a stream of incoming spike packets into time-aligned axon activations. Each packet names one destination axon and the time, in global ticks, at which its spike was produced. A single delay value, loaded once during startup, is added to that time, and the resulting 5-bit release stamp is parked in the destination axon's own slot. Whenever the global tick strobe fires, every slot holding a pending stamp equal to the global time counter raises its axon's spike line for exactly one core clock cycle and then forgets the stamp.

One adder and one address decoder serve all axons. The adder result is registered, and in the following cycle the decoder writes it into the addressed slot. Because each slot keeps its own stamp, the packet input never waits: it takes a packet in every cycle. The global tick strobe has no fixed phase relation to the core clock, so it passes through a two-flop synchronizer and an edge detector before it reaches the slots. The global time counter must hold its value from the rise of the tick strobe until the release cycle.

Top module: `spk_scheduler`

## Requirements
- R1: After reset no slot holds a pending stamp, no spike line is high, and a tick at any global time releases no spike.
- R2: `pkt_ready` is high in every cycle, so a packet is taken on every cycle in which `pkt_valid` is high. The input never applies back-pressure.
- R3: An accepted packet for axon A with time T makes A pending with stamp (T + D) mod 32, where D is the delay value in force when the packet is accepted. A tick whose `glb_time` equals that stamp raises bit A of `spike_out`.
- R4: A cycle with `cfg_delay_we` high loads `cfg_delay` as the new 4-bit delay D. Packets accepted in later cycles use the new value.
- R5: Bit 0 of `glb_tick` is sampled by the core clock. If it rises before clock edge E1, the release appears on `spike_out` from edge E3 to edge E4. It is low before E3 and low again after E4.
- R6: A slot clears its pending flag in the cycle in which it releases. A later tick at the same global time does not fire that axon again.
- R7: A second packet for an axon that is already pending replaces its stamp. The old stamp no longer fires and the new one does.
- R8: A tick strobe held high produces one release only. Stamps that match while it stays high wait for the next rise.
- R9: All pending axons whose stamp matches the global time release in the same cycle.
- R10: The stamp sum wraps modulo 32. A time of 20 with a delay of 15 fires at global time 3.
- R11: A tick at a global time that differs from a pending stamp leaves the axon pending and its spike line low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Packet present on `pkt_axon` and `pkt_time` |
| pkt_ready | output | 1 | Always high: the scheduler takes a packet every cycle |
| pkt_axon | input | 10 | Destination axon index |
| pkt_time | input | 5 | Spike time of the packet in global ticks |
| cfg_delay_we | input | 1 | Load strobe for the shared delay value |
| cfg_delay | input | 4 | Delay value in global ticks |
| glb_tick | input | 1 | Global tick strobe, asynchronous to `clk` |
| glb_time | input | 5 | Global time counter, stable across each tick release |
| spike_out | output | 1024 | Per-axon spike lines, each a one-cycle pulse |

## Verification
The bench samples the spike vector one cycle before and one cycle after the expected release cycle. A synchronizer with a stage too few or too many therefore shows up as an early or late pulse. A design that adds without wrapping at 32 would never fire a wrapped stamp. A design that keeps the pending flag set would fire a second time when the same global time comes back. A design that appends instead of replacing would fire at the stale stamp of an overwritten axon. A tick held high over several cycles exposes a missing edge detector, which would release a second time. Random traffic is aimed at a narrow range of axons and at stamps that are already pending, so that simultaneous releases and updates with a new delay happen often.

// File: rtl/spk_sched_pkg.sv
package spk_sched_pkg;
  localparam int DEF_AXONS = 1024;
  localparam int DEF_TS_W  = 5;
  localparam int DEF_DLY_W = 4;
  localparam int DEF_SYNC  = 2;
endpackage

// File: rtl/spk_tick_sync.sv
module spk_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_async,
  output logic tick_pulse
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q[0] <= tick_async;
      prev_q     <= chain_q[STAGES-1];
    end
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q[s] <= 1'b0;
        else        chain_q[s] <= chain_q[s-1];
      end
    end
  endgenerate

  assign tick_pulse = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/spk_stamp_stage.sv
module spk_stamp_stage #(
  parameter int AX_W  = 10,
  parameter int TS_W  = 5,
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_fire,
  input  logic [AX_W-1:0]  in_axon,
  input  logic [TS_W-1:0]  in_time,
  input  logic             cfg_we,
  input  logic [DLY_W-1:0] cfg_delay,
  output logic             out_valid,
  output logic [AX_W-1:0]  out_axon,
  output logic [TS_W-1:0]  out_stamp,
  output logic [DLY_W-1:0] delay_q
);
  logic [TS_W-1:0] sum;

  // modular add: the carry out of TS_W bits is dropped
  always_comb sum = in_time + TS_W'(delay_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      delay_q   <= '0;
      out_valid <= 1'b0;
      out_axon  <= '0;
      out_stamp <= '0;
    end else begin
      if (cfg_we) delay_q <= cfg_delay;
      out_valid <= in_fire;
      if (in_fire) begin
        out_axon  <= in_axon;
        out_stamp <= sum;
      end
    end
  end
endmodule

// File: rtl/spk_release_slot.sv
module spk_release_slot #(
  parameter int TS_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [TS_W-1:0] wr_stamp,
  input  logic            rel_en,
  input  logic [TS_W-1:0] now_time,
  output logic            pending,
  output logic            spike
);
  logic [TS_W-1:0] stamp_q;
  logic            hit;

  always_comb hit = pending & rel_en & (stamp_q == now_time);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      stamp_q <= '0;
      spike   <= 1'b0;
    end else begin
      spike <= hit;
      if (wr_en) begin
        pending <= 1'b1;
        stamp_q <= wr_stamp;
      end else if (hit) begin
        pending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spk_scheduler.sv
module spk_scheduler
  import spk_sched_pkg::*;
#(
  parameter int NUM_AXONS = DEF_AXONS,
  parameter int TS_W      = DEF_TS_W,
  parameter int DLY_W     = DEF_DLY_W,
  parameter int SYNC_STG  = DEF_SYNC,
  localparam int AX_W     = (NUM_AXONS > 1) ? $clog2(NUM_AXONS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pkt_valid,
  output logic                 pkt_ready,
  input  logic [AX_W-1:0]      pkt_axon,
  input  logic [TS_W-1:0]      pkt_time,
  input  logic                 cfg_delay_we,
  input  logic [DLY_W-1:0]     cfg_delay,
  input  logic                 glb_tick,
  input  logic [TS_W-1:0]      glb_time,
  output logic [NUM_AXONS-1:0] spike_out
);
  logic             tick_pulse;
  logic             st_valid;
  logic [AX_W-1:0]  st_axon;
  logic [TS_W-1:0]  st_stamp;
  logic [DLY_W-1:0] delay_q;
  logic [NUM_AXONS-1:0] slot_pend;
  logic [NUM_AXONS-1:0] slot_wr;

  assign pkt_ready = 1'b1;

  spk_tick_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_async(glb_tick),
    .tick_pulse(tick_pulse)
  );

  spk_stamp_stage #(.AX_W(AX_W), .TS_W(TS_W), .DLY_W(DLY_W)) u_stamp (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_fire  (pkt_valid & pkt_ready),
    .in_axon  (pkt_axon),
    .in_time  (pkt_time),
    .cfg_we   (cfg_delay_we),
    .cfg_delay(cfg_delay),
    .out_valid(st_valid),
    .out_axon (st_axon),
    .out_stamp(st_stamp),
    .delay_q  (delay_q)
  );

  generate
    for (genvar i = 0; i < NUM_AXONS; i++) begin : g_slot
      always_comb slot_wr[i] = st_valid & (st_axon == AX_W'(i));

      spk_release_slot #(.TS_W(TS_W)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (slot_wr[i]),
        .wr_stamp(st_stamp),
        .rel_en  (tick_pulse),
        .now_time(glb_time),
        .pending (slot_pend[i]),
        .spike   (spike_out[i])
      );
    end
  endgenerate
endmodule

// File: rtl/spk_sched_checker.sv
module spk_sched_checker #(
  parameter int N     = 1024,
  parameter int AX_W  = 10,
  parameter int DLY_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_pulse,
  input logic [N-1:0]     spike_out,
  input logic [N-1:0]     slot_pend,
  input logic             st_valid,
  input logic [AX_W-1:0]  st_axon,
  input logic             cfg_delay_we,
  input logic [DLY_W-1:0] delay_q
);
  // R5: spikes only in the cycle after a synchronized tick edge
  a_r5_spike_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (|spike_out) |-> $past(tick_pulse));

  // R5: a release lasts exactly one cycle
  a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (|spike_out) |=> (spike_out == '0));

  // R8: a synchronized tick edge is never two cycles long
  a_r8_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tick_pulse |=> !tick_pulse);

  // R6: only a slot that was pending may spike
  a_r6_spike_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (spike_out & ~$past(slot_pend)) == '0);

  // R3: the decoded stamp lands in the addressed slot
  a_r3_slot_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |=> slot_pend[$past(st_axon)]);

  // R4: the delay changes only on a load strobe
  a_r4_delay_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_delay_we |=> $stable(delay_q));
endmodule

bind spk_scheduler spk_sched_checker #(.N(NUM_AXONS), .AX_W(AX_W), .DLY_W(DLY_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_pulse  (tick_pulse),
  .spike_out   (spike_out),
  .slot_pend   (slot_pend),
  .st_valid    (st_valid),
  .st_axon     (st_axon),
  .cfg_delay_we(cfg_delay_we),
  .delay_q     (delay_q)
);

// File: tb/tb_spk_scheduler.sv
`timescale 1ns/1ps
module tb_spk_scheduler;
  localparam int N    = 1024;
  localparam int AX_W = 10;
  localparam int TS_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pkt_valid = 1'b0;
  logic pkt_ready;
  logic [AX_W-1:0] pkt_axon = '0;
  logic [TS_W-1:0] pkt_time = '0;
  logic cfg_delay_we = 1'b0;
  logic [3:0] cfg_delay = '0;
  logic glb_tick = 1'b0;
  logic [TS_W-1:0] glb_time = '0;
  logic [N-1:0] spike_out;

  int checks = 0;
  int fails  = 0;

  bit m_pend [N];
  int m_ts   [N];
  int m_delay = 0;

  always #2 clk = ~clk;

  spk_scheduler dut (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_axon(pkt_axon), .pkt_time(pkt_time), .cfg_delay_we(cfg_delay_we),
    .cfg_delay(cfg_delay), .glb_tick(glb_tick), .glb_time(glb_time),
    .spike_out(spike_out)
  );

  task automatic check_bit(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_vec(input logic [N-1:0] exp, input string req);
    int diffs = 0;
    int first = -1;
    for (int i = 0; i < N; i++)
      if (spike_out[i] !== exp[i]) begin
        diffs++;
        if (first < 0) first = i;
      end
    checks++;
    if (diffs != 0) begin
      fails++;
      $display("FAIL %s axon %0d actual=%0b expected=%0b (%0d bits differ)",
               req, first, spike_out[first], exp[first], diffs);
    end
  endtask

  function automatic logic [N-1:0] expect_release(input int g);
    logic [N-1:0] v = '0;
    for (int i = 0; i < N; i++) v[i] = m_pend[i] && (m_ts[i] == g);
    return v;
  endfunction

  task automatic set_delay(input int d);
    @(negedge clk);
    cfg_delay_we = 1'b1;
    cfg_delay = 4'(d);
    @(negedge clk);
    cfg_delay_we = 1'b0;
    m_delay = d;
  endtask

  task automatic send(input int a, input int t);
    @(negedge clk);
    pkt_valid = 1'b1;
    pkt_axon = AX_W'(a);
    pkt_time = TS_W'(t);
    check_bit(pkt_ready === 1'b1, "R2 ready", int'(pkt_ready), 1);
    @(negedge clk);
    pkt_valid = 1'b0;
    m_pend[a] = 1'b1;
    m_ts[a] = (t + m_delay) % 32;
  endtask

  task automatic do_tick(input int g, input string req);
    logic [N-1:0] exp;
    @(negedge clk);
    repeat (2) @(negedge clk);
    glb_time = TS_W'(g);
    glb_tick = 1'b1;
    exp = expect_release(g);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check_vec('0, "R5 early");
    @(negedge clk);
    check_vec(exp, req);
    for (int i = 0; i < N; i++) if (exp[i]) m_pend[i] = 1'b0;
    @(negedge clk);
    check_vec('0, "R5 width");
    glb_tick = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int unsigned seed = 32'd7;
    logic [N-1:0] z;
    for (int i = 0; i < N; i++) begin m_pend[i] = 1'b0; m_ts[i] = 0; end
    repeat (4) @(negedge clk);
    // R1: idle outputs in and right after reset
    check_vec('0, "R1 reset");
    check_bit(pkt_ready === 1'b1, "R2 reset", int'(pkt_ready), 1);
    rst_n = 1'b1;
    do_tick(0, "R1 no pending");

    // R3, R11, R6
    set_delay(3);
    send(5, 10);
    do_tick(12, "R11 mismatch");
    check_bit(m_pend[5], "R11 still pending", int'(m_pend[5]), 1);
    do_tick(13, "R3 release");
    do_tick(13, "R6 cleared");

    // R10 wrap
    set_delay(15);
    send(7, 20);
    do_tick(3, "R10 wrap");

    // R7 overwrite
    send(9, 1);
    send(9, 2);
    do_tick(16, "R7 old stamp");
    do_tick(17, "R7 new stamp");

    // R9 simultaneous, R4 new delay
    set_delay(2);
    send(0, 13);
    send(1023, 13);
    send(500, 13);
    do_tick(15, "R9 together");

    // R8 held tick
    send(33, 4);
    @(negedge clk);
    glb_time = 5'd6;
    glb_tick = 1'b1;
    z = expect_release(6);
    repeat (3) @(negedge clk);
    check_vec(z, "R8 first");
    m_pend[33] = 1'b0;
    send(34, 4);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check_vec('0, "R8 held");
    end
    glb_tick = 1'b0;
    repeat (3) @(negedge clk);
    do_tick(6, "R8 next rise");

    // random traffic on a narrow axon window
    for (int it = 0; it < 80; it++) begin
      int np = $urandom(seed) % 5;
      int g;
      seed = 0;
      if ($urandom % 6 == 0) set_delay($urandom % 16);
      for (int p = 0; p < np; p++) send($urandom % 16, $urandom % 32);
      g = $urandom % 32;
      if ($urandom % 2 == 0)
        for (int i = 0; i < 16; i++) if (m_pend[i]) g = m_ts[i];
      do_tick(g, "R3 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule